// File: doc/BRIEF.md
# Fixed-Latency Request-Grant Monitor

This block is a synthesizable watchdog for a handshake whose grant must come back a fixed number of clock cycles after the request. It samples a one-bit request and a one-bit grant on each rising clock edge. A request seen at edge t opens a check, and that check is met only if grant is high at edge t+LATENCY. A check that fails raises a registered one-cycle error pulse and latches a sticky error flag. The flag stays set until reset.

Each request is recorded in a history shift register LATENCY bits wide. A new request enters at bit 0 and moves one place toward the top bit each cycle. The top bit marks the cycle in which a grant is due. Every in-flight request therefore has its own bit, so overlapping requests are judged one by one. A second request cannot hide a missed first one.

A small state machine tracks the monitor's condition:
- ST_IDLE: no request is in flight.
- ST_TRACK: at least one check is pending.
- ST_FAULT: at least one check has failed.

Its transitions are:
- IDLE_TO_TRACK: a request arrives.
- TRACK_TO_IDLE: the last pending check leaves the history without a failure.
- TRACK_TO_FAULT: a due grant is missing.
- RESET_TO_IDLE: reset is asserted, from any state.

ST_FAULT is held until reset. The sticky flag is high exactly in ST_FAULT.

Top module: `rgc_latency_mon`

## Requirements
- R1: If req is high at edge t and gnt is low at edge t+LATENCY (LATENCY defaults to 4), err_pulse is high for exactly the cycle after edge t+LATENCY.
- R2: If req is high at edge t and gnt is high at edge t+LATENCY, that request produces no err_pulse.
- R3: Requests that overlap in time are checked separately. A missed grant for the first request gives one pulse even when the second request is granted on time.
- R4: Requests on consecutive edges whose grants are all missing give one err_pulse per request, on consecutive cycles.
- R5: A gnt at an edge where no request is due never causes err_pulse or err_sticky.
- R6: err_sticky goes high at the same edge as the first err_pulse. It stays high, with no further failures needed, until rst.
- R7: While rst (active high, synchronous) is high, err_pulse and err_sticky are low and req is ignored. A request accepted before reset never causes an error after reset.
- R8: A grant one cycle early or one cycle late does not satisfy a request. That request still produces err_pulse at edge t+LATENCY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; drops all pending checks |
| req | input | 1 | Request, sampled each rising edge |
| gnt | input | 1 | Grant, sampled each rising edge |
| err_pulse | output | 1 | Registered one-cycle pulse per failed request |
| err_sticky | output | 1 | Set on the first failure, held until reset |

## Verification
The assertions assume that req and gnt are clean single-bit levels that are stable around each rising edge. They also assume that reset lasts at least one edge, so the history is empty when checking resumes. The bench changes req, gnt and rst only on falling edges. It asserts reset for two full cycles at the start and again in the middle of the run. Input patterns are chosen only to exercise legal timing, and the bench's own per-cycle reference decides whether a pulse is due.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_FAULT = 2'd2
    } mon_state_t;
endpackage

// File: rtl/rgc_history.sv
// Records each request and shifts it toward the top bit, which marks the due cycle.
module rgc_history #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic due,
    output logic pending_next
);
    localparam int TOP = LATENCY - 1;

    logic [TOP:0] hist;
    logic [TOP:0] hist_nxt;

    generate
        if (LATENCY == 1) begin : g_single
            assign hist_nxt = req;
        end else begin : g_shift
            assign hist_nxt = {hist[TOP-1:0], req};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= hist_nxt;
    end

    assign due          = hist[TOP];
    assign pending_next = |hist_nxt;

    // R7
    hist_reset_chk: assert property (@(posedge clk) rst |=> (hist == '0))
        else $error("history not empty after reset");
endmodule

// File: rtl/rgc_ctrl.sv
// State machine and registered error outputs.
module rgc_ctrl
    import rgc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic due,
    input  logic gnt,
    input  logic pending_next,
    output logic err_pulse,
    output logic err_sticky
);
    mon_state_t state, state_nxt;
    logic       miss;

    assign miss = due && !gnt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (pending_next) state_nxt = ST_TRACK;
            ST_TRACK: begin
                if (miss)               state_nxt = ST_FAULT;
                else if (!pending_next) state_nxt = ST_IDLE;
            end
            ST_FAULT: state_nxt = ST_FAULT;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) err_pulse <= 1'b0;
        else     err_pulse <= miss;
    end

    assign err_sticky = (state == ST_FAULT);

    // R5
    idle_no_due_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !due)
        else $error("grant due while monitor idle");

    // R6
    pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky)
        else $error("pulse without sticky flag");
endmodule

// File: rtl/rgc_latency_mon.sv
module rgc_latency_mon #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic gnt,
    output logic err_pulse,
    output logic err_sticky
);
    logic due;
    logic pending_next;

    rgc_history #(.LATENCY(LATENCY)) u_hist (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .due          (due),
        .pending_next (pending_next)
    );

    rgc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .due          (due),
        .gnt          (gnt),
        .pending_next (pending_next),
        .err_pulse    (err_pulse),
        .err_sticky   (err_sticky)
    );

    // R2
    granted_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> !$past(gnt))
        else $error("pulse after a granted cycle");

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky)
        else $error("sticky flag dropped without reset");

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!err_pulse && !err_sticky))
        else $error("outputs not clear after reset");
endmodule

// File: tb/sim_rgc_latency_mon.sv
`timescale 1ns/1ps
module sim_rgc_latency_mon;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic gnt = 1'b0;
    logic err_pulse, err_sticky;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rst_end = 0;
    bit reqlog [0:4095];
    bit exp_s = 1'b0;

    always #2.5 clk = ~clk;

    rgc_latency_mon #(.LATENCY(LAT)) u0 (
        .clk(clk), .rst(rst), .req(req), .gnt(gnt),
        .err_pulse(err_pulse), .err_sticky(err_sticky)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s cycle %0d: actual=%b expected=%b", tag, what, cyc, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare just after the rising edge.
    task automatic tick(input logic rs, input logic r, input logic g, input string tag);
        bit exp_p;
        @(negedge clk);
        rst = rs; req = r; gnt = g;
        @(posedge clk);
        #1;
        reqlog[cyc] = r && !rs;
        exp_p = 1'b0;
        if (rs) begin
            exp_s = 1'b0;
            rst_end = cyc + 1;
        end else if (cyc >= LAT && (cyc - LAT) >= rst_end) begin
            exp_p = reqlog[cyc-LAT] && !g;
        end
        if (exp_p) exp_s = 1'b1;
        check(tag, "err_pulse", err_pulse, exp_p);
        check(tag, "err_sticky", err_sticky, exp_s);
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic t_reset;            // R7
        tick(1'b1, 1'b1, 1'b1, "R7");
        tick(1'b1, 1'b0, 1'b0, "R7");
        idle(LAT + 1, "R7");
    endtask

    task automatic t_granted;          // R2
        tick(1'b0, 1'b1, 1'b0, "R2");
        for (int i = 1; i < LAT; i++) tick(1'b0, 1'b0, 1'b0, "R2");
        tick(1'b0, 1'b0, 1'b1, "R2");
        idle(2, "R2");
    endtask

    task automatic t_lone_grant;       // R5
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'b1, "R5");
        idle(2, "R5");
    endtask

    task automatic t_miss_and_hold;    // R1, R6
        tick(1'b0, 1'b1, 1'b0, "R1");
        idle(LAT + 1, "R1");
        idle(8, "R6");
    endtask

    task automatic t_overlap;          // R3
        tick(1'b0, 1'b1, 1'b0, "R3");
        tick(1'b0, 1'b1, 1'b0, "R3");
        for (int i = 2; i < LAT; i++) tick(1'b0, 1'b0, 1'b0, "R3");
        tick(1'b0, 1'b0, 1'b0, "R3");
        tick(1'b0, 1'b0, 1'b1, "R3");
        idle(2, "R3");
    endtask

    task automatic t_burst;            // R4
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b0, "R4");
        idle(LAT + 3, "R4");
    endtask

    task automatic t_off_by_one;       // R8
        tick(1'b0, 1'b1, 1'b0, "R8");
        for (int i = 1; i < LAT - 1; i++) tick(1'b0, 1'b0, 1'b0, "R8");
        tick(1'b0, 1'b0, 1'b1, "R8");
        tick(1'b0, 1'b0, 1'b0, "R8");
        tick(1'b0, 1'b0, 1'b1, "R8");
        idle(2, "R8");
    endtask

    task automatic t_midflight_reset;  // R7
        tick(1'b0, 1'b1, 1'b0, "R7");
        tick(1'b0, 1'b1, 1'b0, "R7");
        tick(1'b1, 1'b0, 1'b0, "R7");
        tick(1'b1, 1'b0, 1'b0, "R7");
        idle(LAT + 3, "R7");
    endtask

    initial begin
        t_reset();
        t_granted();
        t_lone_grant();
        t_miss_and_hold();
        t_reset();
        t_overlap();
        t_reset();
        t_burst();
        t_reset();
        t_off_by_one();
        t_reset();
        t_midflight_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule